// File: doc/BRIEF.md
# PC-Relative Store Sequencer over a Shared Bus

This block is a 16-bit datapath and its control sequencer. Together they carry out one instruction: a store whose target address is the program counter plus a signed offset taken from the instruction word. The datapath has these parts:

- a program counter and an instruction holding register
- an eight-entry register file
- an address adder fed by two operand selectors
- an ALU with add, and, not and pass-A operations
- an address holding register
- a data holding register with its own input selector
- a small word-addressed memory

Every transfer between these parts goes through one shared bus. A value written into a register can be used only in the cycle after it is written. For that reason the store takes three steps: latch the address, latch the data, then write the memory.

The surrounding test logic loads the program counter, the instruction word and the register file through direct load inputs. It then pulses `start`. The sequencer drives all the selects, bus drivers and load enables for each step at the same time. It raises `done` for one cycle after the memory write. The address register, the data register and the program counter are brought out as ports, and there is a read-only peek port into the memory.

Top module: `stseq_top`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0, and `pc_q`, `addr_q`, `data_q`, every register-file entry and every memory word are 0.
- R2: A `start` pulse sampled while idle makes `busy` read 1 for exactly the three cycles after that edge. `done` then reads 1 for the single cycle after the third cycle, with `busy` at 0.
- R3: At the end of the first step, `addr_q` holds `pc_q` plus the sign extension of instruction bits [8:0], taken modulo 2^16. `addr_q` does not change in any cycle in which it is not being loaded.
- R4: At the end of the second step, `data_q` holds the register-file entry numbered by instruction bits [11:9].
- R5: At the end of the third step, the memory word at index `addr_q[5:0]` holds `data_q`. No other memory word changes.
- R6: The store leaves `pc_q` unchanged.
- R7: A `start` that arrives while a store is in progress is ignored. No extra `done` follows and the running store is not restarted. A `start` in the `done` cycle begins a new store.
- R8: In any cycle, at most one source (adder, ALU, PC, data register) drives the shared bus.
- R9: Test loads of the instruction word, the PC and the register file that arrive while `busy` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a store when idle |
| busy | output | 1 | A store is in progress |
| done | output | 1 | One-cycle pulse after the memory write |
| ir_wr | input | 1 | Load `ir_din` into the instruction register (idle only) |
| ir_din | input | 16 | Instruction word |
| pc_wr | input | 1 | Load `pc_din` into the PC (idle only) |
| pc_din | input | 16 | PC value |
| rf_wr | input | 1 | Write `rf_din` into register `rf_wsel` (idle only) |
| rf_wsel | input | 3 | Register-file write index |
| rf_din | input | 16 | Register-file write data |
| pc_q | output | 16 | Current PC |
| addr_q | output | 16 | Address holding register |
| data_q | output | 16 | Data holding register |
| peek_addr | input | 6 | Memory peek index |
| peek_data | output | 16 | Memory word at `peek_addr` |

## Verification
Two things can land on the same clock edge. The first is a new `start` against a store that is still running, including a `start` held across its steps and one raised exactly in the `done` cycle. The second is a test load of the PC, the instruction word or the source register against the step that reads that value. The bench provokes both by asserting these inputs at the negative edge inside a running store. It judges them by checking that the latched address, the latched data, the PC, `busy` and `done` all follow the values in place before the store began. It also checks that the chained `start` produces a second correct store.

// File: rtl/stseq_pkg.sv
package stseq_pkg;

    localparam int WORD_W    = 16;
    localparam int REG_SEL_W = 3;
    localparam int REG_CNT   = 1 << REG_SEL_W;
    localparam int N_DRIVERS = 4;

    typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_WRITE} step_e;
    typedef enum logic       {A1_PC, A1_BASE} addr1_sel_e;
    typedef enum logic [1:0] {A2_ZERO, A2_OFF6, A2_OFF9, A2_OFF11} addr2_sel_e;
    typedef enum logic       {SR1_HI, SR1_MID} sr1_sel_e;
    typedef enum logic [1:0] {ALU_ADD, ALU_AND, ALU_NOT, ALU_PASSA} alu_op_e;

    typedef struct packed {
        logic       drv_adder;
        logic       drv_alu;
        logic       drv_pc;
        logic       drv_data;
        logic       addr_ld;
        logic       data_ld;
        logic       data_from_mem;
        logic       mem_en;
        logic       mem_wr;
        addr1_sel_e a1;
        addr2_sel_e a2;
        sr1_sel_e   sr1;
        alu_op_e    alu;
    } ctrl_t;

    function automatic step_e next_step(step_e s, logic go);
        case (s)
            ST_IDLE: return go ? ST_ADDR : ST_IDLE;
            ST_ADDR: return ST_DATA;
            ST_DATA: return ST_WRITE;
            default: return ST_IDLE;
        endcase
    endfunction

    function automatic ctrl_t step_ctrl(step_e s);
        ctrl_t c;
        c = '0;
        case (s)
            ST_ADDR: begin
                c.a1        = A1_PC;
                c.a2        = A2_OFF9;
                c.drv_adder = 1'b1;
                c.addr_ld   = 1'b1;
            end
            ST_DATA: begin
                c.sr1           = SR1_HI;
                c.alu           = ALU_PASSA;
                c.drv_alu       = 1'b1;
                c.data_from_mem = 1'b0;
                c.data_ld       = 1'b1;
            end
            ST_WRITE: begin
                c.mem_en = 1'b1;
                c.mem_wr = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/stseq_ctrl.sv
module stseq_ctrl
    import stseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output ctrl_t ctrl,
    output logic  busy,
    output logic  done
);
    step_e step_q;
    logic  done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= ST_IDLE;
            done_q <= 1'b0;
        end else begin
            step_q <= next_step(step_q, start);
            done_q <= (step_q == ST_WRITE);
        end
    end

    assign ctrl = step_ctrl(step_q);
    assign busy = (step_q != ST_IDLE);
    assign done = done_q;

    // R2: the write step is always followed by a done pulse with busy low
    p_done_follows_r2: assert property (@(posedge clk) disable iff (rst)
        (step_q == ST_WRITE) |=> (done && !busy));

    // R7: a running store cannot be restarted
    p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
        busy |=> (step_q != ST_ADDR));

endmodule

// File: rtl/stseq_regfile.sv
module stseq_regfile
    import stseq_pkg::*;
#(
    parameter int DW = WORD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [REG_SEL_W-1:0] wsel,
    input  logic [DW-1:0]        wdata,
    input  logic [REG_SEL_W-1:0] rsel_a,
    input  logic [REG_SEL_W-1:0] rsel_b,
    output logic [DW-1:0]        rdata_a,
    output logic [DW-1:0]        rdata_b
);
    logic [DW-1:0] regs_q [REG_CNT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_CNT; i++) regs_q[i] <= '0;
        end else if (we) begin
            regs_q[wsel] <= wdata;
        end
    end

    assign rdata_a = regs_q[rsel_a];
    assign rdata_b = regs_q[rsel_b];

endmodule

// File: rtl/stseq_mem.sv
module stseq_mem #(
    parameter int DW = 16,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [AW-1:0] peek_addr,
    output logic [DW-1:0] peek_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words_q [DEPTH];
    logic          we;

    assign we = en && wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) words_q[i] <= '0;
        end else if (we) begin
            words_q[addr] <= wdata;
        end
    end

    assign rdata     = words_q[addr];
    assign peek_data = words_q[peek_addr];

    // R5: a write lands at the addressed word
    p_store_lands_r5: assert property (@(posedge clk) disable iff (rst)
        we |=> (words_q[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/stseq_top.sv
module stseq_top
    import stseq_pkg::*;
#(
    parameter int DW  = WORD_W,
    parameter int MAW = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    output logic                 busy,
    output logic                 done,
    input  logic                 ir_wr,
    input  logic [DW-1:0]        ir_din,
    input  logic                 pc_wr,
    input  logic [DW-1:0]        pc_din,
    input  logic                 rf_wr,
    input  logic [REG_SEL_W-1:0] rf_wsel,
    input  logic [DW-1:0]        rf_din,
    output logic [DW-1:0]        pc_q,
    output logic [DW-1:0]        addr_q,
    output logic [DW-1:0]        data_q,
    input  logic [MAW-1:0]       peek_addr,
    output logic [DW-1:0]        peek_data
);
    ctrl_t                 c;
    logic [DW-1:0]         pc_r, ir_r, addr_r, data_r;
    logic [DW-1:0]         off6, off9, off11;
    logic [DW-1:0]         op1, op2, adder_y;
    logic [DW-1:0]         rd_a, rd_b, alu_y;
    logic [DW-1:0]         bus, mem_rd, data_d;
    logic [REG_SEL_W-1:0]  sr1_idx;
    logic [N_DRIVERS-1:0]  drivers;

    stseq_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctrl  (c),
        .busy  (busy),
        .done  (done)
    );

    // Test-side loads take effect only while idle
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_r <= '0;
            ir_r <= '0;
        end else if (!busy) begin
            if (pc_wr) pc_r <= pc_din;
            if (ir_wr) ir_r <= ir_din;
        end
    end

    assign sr1_idx = (c.sr1 == SR1_HI) ? ir_r[11:9] : ir_r[8:6];

    stseq_regfile #(.DW(DW)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_wr && !busy),
        .wsel    (rf_wsel),
        .wdata   (rf_din),
        .rsel_a  (sr1_idx),
        .rsel_b  (ir_r[2:0]),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    // Address adder and its operand selectors
    assign off6  = {{(DW-6){ir_r[5]}},   ir_r[5:0]};
    assign off9  = {{(DW-9){ir_r[8]}},   ir_r[8:0]};
    assign off11 = {{(DW-11){ir_r[10]}}, ir_r[10:0]};

    assign op1 = (c.a1 == A1_PC) ? pc_r : rd_a;

    always_comb begin
        case (c.a2)
            A2_OFF6:  op2 = off6;
            A2_OFF9:  op2 = off9;
            A2_OFF11: op2 = off11;
            default:  op2 = '0;
        endcase
    end

    assign adder_y = op1 + op2;

    always_comb begin
        case (c.alu)
            ALU_ADD: alu_y = rd_a + rd_b;
            ALU_AND: alu_y = rd_a & rd_b;
            ALU_NOT: alu_y = ~rd_a;
            default: alu_y = rd_a;
        endcase
    end

    // Shared bus as an AND-OR of gated sources
    assign drivers = {c.drv_adder, c.drv_alu, c.drv_pc, c.drv_data};
    assign bus = ({DW{c.drv_adder}} & adder_y)
               | ({DW{c.drv_alu}}   & alu_y)
               | ({DW{c.drv_pc}}    & pc_r)
               | ({DW{c.drv_data}}  & data_r);

    assign data_d = c.data_from_mem ? mem_rd : bus;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_r <= '0;
            data_r <= '0;
        end else begin
            if (c.addr_ld) addr_r <= bus;
            if (c.data_ld) data_r <= data_d;
        end
    end

    stseq_mem #(.DW(DW), .AW(MAW)) u_mem (
        .clk       (clk),
        .rst       (rst),
        .en        (c.mem_en),
        .wr        (c.mem_wr),
        .addr      (addr_r[MAW-1:0]),
        .wdata     (data_r),
        .rdata     (mem_rd),
        .peek_addr (peek_addr),
        .peek_data (peek_data)
    );

    assign pc_q   = pc_r;
    assign addr_q = addr_r;
    assign data_q = data_r;

    // R8: never two bus drivers at once
    p_one_driver_r8: assert property (@(posedge clk) disable iff (rst)
        $countones(drivers) <= 1);

    // R3: the address register holds unless loaded
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !c.addr_ld |=> $stable(addr_r));

    // R6 / R9: PC stays put during a store
    p_pc_stable_r6: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(pc_r));

    // R9: instruction word stays put during a store
    p_ir_stable_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ir_r));

endmodule

// File: tb/stseq_top_tb_top.sv
module stseq_top_tb_top;
    localparam int DW  = 16;
    localparam int MAW = 6;
    localparam int DEP = 1 << MAW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          busy, done;
    logic          ir_wr = 1'b0, pc_wr = 1'b0, rf_wr = 1'b0;
    logic [DW-1:0] ir_din = '0, pc_din = '0, rf_din = '0;
    logic [2:0]    rf_wsel = '0;
    logic [DW-1:0] pc_q, addr_q, data_q, peek_data;
    logic [MAW-1:0] peek_addr = '0;

    int n_chk = 0;
    int n_bad = 0;

    logic [DW-1:0] rf_m  [8];
    logic [DW-1:0] mem_m [DEP];
    logic [DW-1:0] cur_pc, cur_ir;

    always #5 clk = ~clk;

    stseq_top #(.DW(DW), .MAW(MAW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .ir_wr(ir_wr), .ir_din(ir_din), .pc_wr(pc_wr), .pc_din(pc_din),
        .rf_wr(rf_wr), .rf_wsel(rf_wsel), .rf_din(rf_din),
        .pc_q(pc_q), .addr_q(addr_q), .data_q(data_q),
        .peek_addr(peek_addr), .peek_data(peek_data)
    );

    function automatic logic [DW-1:0] exp_addr(logic [DW-1:0] pc, logic [DW-1:0] ir);
        return pc + {{(DW-9){ir[8]}}, ir[8:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic set_reg(input int idx, input logic [DW-1:0] v);
        @(negedge clk);
        rf_wr = 1'b1; rf_wsel = idx[2:0]; rf_din = v;
        @(negedge clk);
        rf_wr = 1'b0;
        rf_m[idx] = v;
    endtask

    task automatic set_pc_ir(input logic [DW-1:0] pc, input logic [DW-1:0] ir);
        @(negedge clk);
        pc_wr = 1'b1; pc_din = pc; ir_wr = 1'b1; ir_din = ir;
        @(negedge clk);
        pc_wr = 1'b0; ir_wr = 1'b0;
        cur_pc = pc; cur_ir = ir;
    endtask

    task automatic check_mem_all(input string req);
        bit ok = 1'b1;
        logic [DW-1:0] a_bad = '0, e_bad = '0;
        for (int a = 0; a < DEP; a++) begin
            peek_addr = a[MAW-1:0];
            #1;
            if (peek_data !== mem_m[a] && ok) begin
                ok = 1'b0; a_bad = peek_data; e_bad = mem_m[a];
            end
        end
        check(ok, req, a_bad, e_bad);
    endtask

    // chained: start is raised at the current negedge (the done cycle)
    task automatic run_store(input bit chained, input bit poke_start, input bit poke_loads);
        logic [DW-1:0] ea, dv;
        int src;
        ea  = exp_addr(cur_pc, cur_ir);
        src = int'(cur_ir[11:9]);
        dv  = rf_m[src];
        if (!chained) @(negedge clk);
        start = 1'b1;
        @(negedge clk);                      // after accept edge
        start = poke_start;
        check(busy === 1'b1, "R2 busy step1", {15'd0, busy}, 16'd1);
        if (poke_loads) begin
            pc_wr = 1'b1; pc_din = ~cur_pc;
            ir_wr = 1'b1; ir_din = ~cur_ir;
            rf_wr = 1'b1; rf_wsel = cur_ir[11:9]; rf_din = ~dv;
        end
        @(negedge clk);                      // after address step
        pc_wr = 1'b0; ir_wr = 1'b0; rf_wr = 1'b0;
        check(addr_q === ea, "R3 address", addr_q, ea);
        check(busy === 1'b1 && done === 1'b0, "R2 busy step2", {15'd0, busy}, 16'd1);
        @(negedge clk);                      // after data step
        start = 1'b0;
        check(data_q === dv, "R4 data", data_q, dv);
        if (poke_loads) check(data_q === dv, "R9 rf load ignored", data_q, dv);
        check(busy === 1'b1, "R2 busy step3", {15'd0, busy}, 16'd1);
        @(negedge clk);                      // after write step
        mem_m[ea[MAW-1:0]] = dv;
        check(done === 1'b1 && busy === 1'b0, "R2 done pulse", {15'd0, done}, 16'd1);
        check(pc_q === cur_pc, "R6 pc kept", pc_q, cur_pc);
        if (poke_loads) check(pc_q === cur_pc, "R9 pc load ignored", pc_q, cur_pc);
        peek_addr = ea[MAW-1:0];
        #1;
        check(peek_data === dv, "R5 word written", peek_data, dv);
    endtask

    task automatic after_idle(input string req);
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, req, {14'd0, busy, done}, 16'd0);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) rf_m[i] = '0;
        for (int i = 0; i < DEP; i++) mem_m[i] = '0;
        cur_pc = '0; cur_ir = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy === 1'b0 && done === 1'b0, "R1 idle", {14'd0, busy, done}, 16'd0);
        check(pc_q === '0, "R1 pc", pc_q, 16'd0);
        check(addr_q === '0 && data_q === '0, "R1 holding regs", addr_q | data_q, 16'd0);
        check_mem_all("R1 memory clear");

        // Directed: negative offset wraps below zero (R3)
        set_reg(3, 16'hBEEF);
        set_pc_ir(16'h0000, {4'h0, 3'd3, 9'h100});
        run_store(1'b0, 1'b0, 1'b0);
        after_idle("R2 done one cycle");
        // Directed: positive offset wraps past top (R3), source r7
        set_reg(7, 16'h1234);
        set_pc_ir(16'hFFFF, {4'h0, 3'd7, 9'h0FF});
        run_store(1'b0, 1'b0, 1'b0);
        after_idle("R2 done one cycle");
        check_mem_all("R5 only target changed");

        // Start held during store, loads poked (R7, R9)
        set_reg(0, 16'h00A5);
        set_pc_ir(16'h0100, {4'h0, 3'd0, 9'h012});
        run_store(1'b0, 1'b1, 1'b1);
        after_idle("R7 no restart");
        check(pc_q === cur_pc, "R9 pc after poke", pc_q, cur_pc);

        // Start in the done cycle chains a new store (R7)
        set_reg(5, 16'h5A5A);
        set_pc_ir(16'h0200, {4'h0, 3'd5, 9'h020});
        run_store(1'b0, 1'b0, 1'b0);
        cur_ir = cur_ir;                     // same instruction stored again
        rf_m[5] = 16'h5A5A;
        run_store(1'b1, 1'b0, 1'b0);
        after_idle("R7 chained start");
        check_mem_all("R5 after chain");

        // Random stores
        for (int n = 0; n < 40; n++) begin
            logic [DW-1:0] rpc, rir, rv;
            rpc = DW'($urandom);
            rir = DW'($urandom);
            rv  = DW'($urandom);
            set_reg(int'(rir[11:9]), rv);
            set_pc_ir(rpc, rir);
            run_store(1'b0, bit'($urandom % 2), bit'($urandom % 2));
            after_idle("R7 random idle");
        end
        check_mem_all("R5 random memory");

        finish_run();
    end

endmodule